// File: doc/BRIEF.md
# Codec Link Low-Power Wake and Reset Controller

This block sits on the codec side of a serial audio link and handles the link's low-power behaviour. It runs from a local oscillator clock, which keeps running while the link bit clock is stopped. It decides when the codec drives its serial data output high as a wake request, and when a long high level on the frame sync line counts as a warm reset. It also decides when the bit clock may start again. A long low level on the asynchronous active-low link reset input is a cold reset.

A write to the codec's power-down control register arrives as a one-cycle strobe, `pwrdn_req`, and stops the bit clock. The block has two ways out of power-down:

- **Local wake.** A local wake event drives `sdin_drive` high. It stays high until the controller answers with a warm reset, that is until sync has been seen high and then low.
- **Warm reset alone.** A warm reset from the controller with no local wake pending takes the same path, but `sdin_drive` stays low.

In both cases the bit clock stays off until sync has been sampled low, so the first restarted frame does not start falsely. A warm reset leaves register state alone. A cold reset pulses `regs_clear` for one cycle and then brings the link back up.

Top module: `link_wake_ctrl`

## Requirements
- R1: After `sys_rst_n` is released with `link_rst_n` high, `bitclk_en` and `codec_ready` go high once the synchronised reset input is seen high. Both are low while `sys_rst_n` is asserted.
- R2: A `pwrdn_req` strobe while the link is active drops `bitclk_en` and `codec_ready` on the next clock.
- R3: A `wake_evt` while the link is powered down raises `sdin_drive` on the next clock. It stays high for at least `PULSE_CYC` cycles.
- R4: Once raised, `sdin_drive` stays high until sync has been high for `PULSE_CYC` consecutive synchronised samples and then sampled low. It falls on the clock after that low sample.
- R5: While powered down with no wake pending, a sync high of at least `PULSE_CYC` samples is a warm reset. It leaves `sdin_drive` low and does not pulse `regs_clear`.
- R6: A sync high shorter than `PULSE_CYC` samples while powered down has no effect: the bit clock stays off, and a pending wake drive stays high.
- R7: After a warm reset, `bitclk_en` rises on the clock after sync is first sampled low. `codec_ready` rises one clock later.
- R8: `link_rst_n` low for `PULSE_CYC` consecutive synchronised samples, from any state, produces the following:
  - `regs_clear` pulses exactly once, for one cycle.
  - `bitclk_en`, `codec_ready` and `sdin_drive` are low until the reset input returns high.
  - The link then becomes active.
- R9: A `link_rst_n` low shorter than `PULSE_CYC` samples has no effect on any output.
- R10: `wake_evt` while active and `pwrdn_req` while powered down are ignored.
- R11: `sync_in` and `link_rst_n` each pass through `SYNC_STAGES` flip-flops before any decision uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| sys_rst_n | input | 1 | Local power-on reset, active low, asynchronous |
| link_rst_n | input | 1 | Link cold reset, active low, asynchronous to `clk` |
| sync_in | input | 1 | Frame sync line from the controller |
| pwrdn_req | input | 1 | Strobe from a write to the power-down control register |
| wake_evt | input | 1 | Local wake event strobe |
| bitclk_en | output | 1 | Bit clock enable |
| sdin_drive | output | 1 | Drives the serial data output high as a wake request |
| codec_ready | output | 1 | Codec ready flag for the frame tag |
| regs_clear | output | 1 | One-cycle strobe that clears codec registers to defaults |

## Verification
The hardest case to reach is a wake event that arrives while sync is already partway through a warm-reset high. In that case the warm-reset qualification finishes before the minimum wake-drive time has passed. The bench powers the link down and raises sync for 100 cycles before pulsing `wake_evt`. It then holds sync high well past both thresholds, so the release waits for the drive time as well as for the sync low. A cold reset that lands while a wake drive is pending, and short glitches on both asynchronous inputs, are reached by timing the input levels in cycle counts against `PULSE_CYC`.

// File: rtl/lwr_pkg.sv
package lwr_pkg;
   typedef enum logic [2:0] {
      ST_ACTIVE  = 3'd0,
      ST_PWRDN   = 3'd1,
      ST_WAKE    = 3'd2,
      ST_SYNCHI  = 3'd3,
      ST_RESTART = 3'd4,
      ST_COLD    = 3'd5
   } lwr_state_e;
endpackage

// File: rtl/lwr_sync.sv
module lwr_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $error("lwr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff[0] <= RST_VAL;
      else        ff[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff[i] <= RST_VAL;
         else        ff[i] <= ff[i-1];
      end
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/lwr_level_timer.sv
module lwr_level_timer #(
   parameter int LIMIT = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic level,
   output logic first,
   output logic reached
);
   initial begin
      if (LIMIT < 2) $error("lwr_level_timer: LIMIT must be at least 2");
   end

   localparam int              CW   = $clog2(LIMIT + 1);
   localparam logic [CW-1:0]   LAST = CW'(LIMIT - 1);
   localparam logic [CW-1:0]   TOP  = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (en && level)  cnt <= (cnt == TOP) ? TOP : cnt + 1'b1;
      else                   cnt <= '0;
   end

   assign first   = en && level && (cnt == LAST);
   assign reached = en && level && (cnt >= LAST);
endmodule

// File: rtl/link_wake_ctrl.sv
module link_wake_ctrl
   import lwr_pkg::*;
#(
   parameter int PULSE_CYC   = 125,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic link_rst_n,
   input  logic sync_in,
   input  logic pwrdn_req,
   input  logic wake_evt,
   output logic bitclk_en,
   output logic sdin_drive,
   output logic codec_ready,
   output logic regs_clear
);
   initial begin
      if (PULSE_CYC < 2)   $error("link_wake_ctrl: PULSE_CYC must be at least 2");
      if (SYNC_STAGES < 2) $error("link_wake_ctrl: SYNC_STAGES must be at least 2");
   end

   localparam int RW = $clog2(PULSE_CYC + 1);

   lwr_state_e state, nxt;
   logic sync_s, rst_s;
   logic rst_first, rst_reach, sync_first, sync_reach, drv_first, drv_reach;
   logic warm_seen, pend;
   logic down_grp;

   // R11: both asynchronous inputs are synchronised before use
   lwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sync (
      .clk(clk), .rst_n(sys_rst_n), .d(sync_in), .q(sync_s));
   lwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rst (
      .clk(clk), .rst_n(sys_rst_n), .d(link_rst_n), .q(rst_s));

   assign down_grp = (state == ST_PWRDN) || (state == ST_WAKE);

   lwr_level_timer #(.LIMIT(PULSE_CYC)) u_rst_tmr (
      .clk(clk), .rst_n(sys_rst_n), .en(1'b1), .level(!rst_s),
      .first(rst_first), .reached(rst_reach));
   lwr_level_timer #(.LIMIT(PULSE_CYC)) u_sync_tmr (
      .clk(clk), .rst_n(sys_rst_n), .en(down_grp), .level(sync_s),
      .first(sync_first), .reached(sync_reach));
   lwr_level_timer #(.LIMIT(PULSE_CYC)) u_drv_tmr (
      .clk(clk), .rst_n(sys_rst_n), .en(state == ST_WAKE), .level(1'b1),
      .first(drv_first), .reached(drv_reach));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_ACTIVE:  if (pwrdn_req) nxt = ST_PWRDN;
         ST_PWRDN:   if (sync_reach) nxt = ST_SYNCHI;
                     else if (wake_evt) nxt = ST_WAKE;
         ST_WAKE:    if ((warm_seen || sync_reach) && drv_reach) nxt = ST_SYNCHI;
         ST_SYNCHI:  if (!sync_s) nxt = ST_RESTART;
         ST_RESTART: nxt = ST_ACTIVE;
         ST_COLD:    if (rst_s) nxt = ST_ACTIVE;
         default:    nxt = ST_COLD;
      endcase
      if (rst_reach) nxt = ST_COLD;   // R8: cold reset wins from any state
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         state      <= ST_COLD;
         pend       <= 1'b0;
         warm_seen  <= 1'b0;
         regs_clear <= 1'b0;
      end else begin
         state      <= nxt;
         regs_clear <= rst_first;
         if (nxt == ST_WAKE)        pend <= 1'b1;
         else if (nxt != ST_SYNCHI) pend <= 1'b0;
         if (!down_grp && state != ST_SYNCHI)  warm_seen <= 1'b0;
         else if (state == ST_WAKE && sync_reach) warm_seen <= 1'b1;
      end
   end

   assign bitclk_en   = (state == ST_ACTIVE) || (state == ST_RESTART);
   assign codec_ready = (state == ST_ACTIVE);
   assign sdin_drive  = (state == ST_WAKE) || (state == ST_SYNCHI && pend);

   // checker state: length of the current wake drive
   logic [RW-1:0] drv_run;
   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n)      drv_run <= '0;
      else if (sdin_drive) drv_run <= (drv_run == RW'(PULSE_CYC)) ? drv_run : drv_run + 1'b1;
      else                 drv_run <= '0;
   end

   a_r2_pwrdn_stops_clk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (codec_ready && pwrdn_req && !rst_reach) |=> (!bitclk_en && !codec_ready));
   a_r3_min_drive: assert property (@(posedge clk) disable iff (!sys_rst_n)
      ($fell(sdin_drive) && state != ST_COLD) |-> (drv_run >= RW'(PULSE_CYC)));
   a_r3_drive_timer_in_drive: assert property (@(posedge clk) disable iff (!sys_rst_n)
      drv_first |-> sdin_drive);
   a_r4_release_on_sync_low: assert property (@(posedge clk) disable iff (!sys_rst_n)
      ($fell(sdin_drive) && state != ST_COLD) |-> ($past(!sync_s) && $past(warm_seen)));
   a_r5_no_clk_while_sync_counts: assert property (@(posedge clk) disable iff (!sys_rst_n)
      sync_first |-> !bitclk_en);
   a_r7_restart_after_low: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (state == ST_RESTART) |-> $past(!sync_s));
   a_r8_clear_only_in_cold: assert property (@(posedge clk) disable iff (!sys_rst_n)
      regs_clear |-> (state == ST_COLD && !bitclk_en && !sdin_drive));
   a_r10_no_drive_when_active: assert property (@(posedge clk) disable iff (!sys_rst_n)
      codec_ready |-> !sdin_drive);
endmodule

// File: tb/link_wake_ctrl_tb.sv
`timescale 1ns/1ps
module link_wake_ctrl_tb;
   localparam int P  = 125;
   localparam int NS = 2;

   logic clk = 0, sys_rst_n = 0, link_rst_n = 1, sync_in = 0, pwrdn_req = 0, wake_evt = 0;
   logic bitclk_en, sdin_drive, codec_ready, regs_clear;
   int checks = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   link_wake_ctrl #(.PULSE_CYC(P), .SYNC_STAGES(NS)) u_dut (
      .clk(clk), .sys_rst_n(sys_rst_n), .link_rst_n(link_rst_n), .sync_in(sync_in),
      .pwrdn_req(pwrdn_req), .wake_evt(wake_evt), .bitclk_en(bitclk_en),
      .sdin_drive(sdin_drive), .codec_ready(codec_ready), .regs_clear(regs_clear));

   // behavioural reference: modes 0 active,1 down,2 waking,3 sync-seen,4 restart,5 cold
   int  m_mode;
   int  rlo, shi, dlen;
   bit  m_seen, m_pend, m_clr;
   bit  sq[$], rq[$];
   int  clr_pulses, last_run, run;

   task automatic model_init();
      m_mode = 5; rlo = 0; shi = 0; dlen = 0; m_seen = 0; m_pend = 0; m_clr = 0;
      sq = {}; rq = {};
      for (int i = 0; i < NS; i++) begin sq.push_back(1'b0); rq.push_back(1'b0); end
   endtask

   always @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) model_init();
      else begin
         bit s, r, down, sreach, dreach;
         int nm;
         s = sq.pop_front(); r = rq.pop_front();
         sq.push_back(sync_in); rq.push_back(link_rst_n);
         down   = (m_mode == 1 || m_mode == 2);
         sreach = down && s && shi >= P - 1;
         dreach = (m_mode == 2) && dlen >= P - 1;
         nm = m_mode;
         case (m_mode)
            0: if (pwrdn_req) nm = 1;
            1: if (sreach) nm = 3; else if (wake_evt) nm = 2;
            2: if ((m_seen || sreach) && dreach) nm = 3;
            3: if (!s) nm = 4;
            4: nm = 0;
            5: if (r) nm = 0;
            default: nm = 5;
         endcase
         if (!r && rlo >= P - 1) nm = 5;
         m_clr = !r && rlo == P - 1;
         if (nm == 2) m_pend = 1; else if (nm != 3) m_pend = 0;
         if (!down && m_mode != 3) m_seen = 0;
         else if (m_mode == 2 && sreach) m_seen = 1;
         rlo  = r ? 0 : (rlo < P ? rlo + 1 : P);
         shi  = (down && s) ? (shi < P ? shi + 1 : P) : 0;
         dlen = (m_mode == 2) ? (dlen < P ? dlen + 1 : P) : 0;
         m_mode = nm;
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
      end
   endtask

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (!done) begin
         chk("R1/R2/R7", "bitclk_en", bitclk_en, (m_mode == 0 || m_mode == 4));
         chk("R7", "codec_ready", codec_ready, (m_mode == 0));
         chk("R3/R4", "sdin_drive", sdin_drive, (m_mode == 2 || (m_mode == 3 && m_pend)));
         chk("R8", "regs_clear", regs_clear, m_clr);
         if (regs_clear) clr_pulses++;
         if (sdin_drive) run++;
         else begin if (run != 0) last_run = run; run = 0; end
      end
   end

   task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
   task automatic strobe_pd(); pwrdn_req = 1; cyc(1); pwrdn_req = 0; endtask
   task automatic strobe_wake(); wake_evt = 1; cyc(1); wake_evt = 0; endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      clr_pulses = 0; last_run = 0; run = 0;
      cyc(1);
      chk("R1", "reset bitclk_en", bitclk_en, 1'b0);
      chk("R1", "reset codec_ready", codec_ready, 1'b0);
      sys_rst_n = 1;
      cyc(10);
      chk("R1", "active after reset", codec_ready, 1'b1);

      // R10: wake in active ignored
      strobe_wake(); cyc(3);
      chk("R10", "no drive in active", sdin_drive, 1'b0);

      // R2: power down
      strobe_pd();
      chk("R2", "bitclk stopped", bitclk_en, 1'b0);
      strobe_pd(); cyc(2);
      chk("R10", "pwrdn while down keeps off", bitclk_en, 1'b0);

      // R6: short sync high
      sync_in = 1; cyc(60); sync_in = 0; cyc(20);
      chk("R6", "short sync no restart", bitclk_en, 1'b0);

      // R5: warm reset without wake
      sync_in = 1; cyc(200);
      chk("R5", "no drive on warm reset", sdin_drive, 1'b0);
      chk("R7", "clk held while sync high", bitclk_en, 1'b0);
      sync_in = 0; cyc(NS + 1);
      chk("R7", "bitclk restarted", bitclk_en, 1'b1);
      cyc(2);
      chk("R7", "ready after restart", codec_ready, 1'b1);
      chk("R5", "warm reset no clear", clr_pulses == 0, 1'b1);

      // R3/R4: wake handshake
      strobe_pd(); strobe_wake(); cyc(1);
      chk("R3", "drive raised", sdin_drive, 1'b1);
      cyc(300);
      chk("R4", "held without sync", sdin_drive, 1'b1);
      sync_in = 1; cyc(50); sync_in = 0; cyc(10);
      chk("R6", "short sync keeps drive", sdin_drive, 1'b1);
      sync_in = 1; cyc(150);
      chk("R4", "held during sync high", sdin_drive, 1'b1);
      sync_in = 0; cyc(NS + 3);
      chk("R4", "released after sync low", sdin_drive, 1'b0);
      chk("R7", "ready after wake", codec_ready, 1'b1);
      chk("R3", "drive width", last_run >= P, 1'b1);

      // R3: sync already high when wake arrives
      strobe_pd(); sync_in = 1; cyc(100); strobe_wake(); cyc(300);
      chk("R3", "late wake still driving", sdin_drive, 1'b1);
      sync_in = 0; cyc(NS + 3);
      chk("R3", "late wake width", last_run >= P, 1'b1);
      chk("R4", "late wake released", sdin_drive, 1'b0);

      // R9: short reset glitch
      link_rst_n = 0; cyc(60); link_rst_n = 1; cyc(10);
      chk("R9", "glitch ignored", codec_ready, 1'b1);
      chk("R9", "glitch no clear", clr_pulses == 0, 1'b1);

      // R8: cold reset from active
      link_rst_n = 0; cyc(200);
      chk("R8", "clk off in cold", bitclk_en, 1'b0);
      chk("R8", "one clear pulse", clr_pulses == 1, 1'b1);
      link_rst_n = 1; cyc(NS + 3);
      chk("R8", "active after cold", codec_ready, 1'b1);

      // R8: cold reset during a pending wake drive
      strobe_pd(); strobe_wake(); cyc(50);
      link_rst_n = 0; cyc(200);
      chk("R8", "drive dropped by cold", sdin_drive, 1'b0);
      chk("R8", "second clear pulse", clr_pulses == 2, 1'b1);
      link_rst_n = 1; cyc(NS + 3);
      chk("R8", "active after cold from down", codec_ready, 1'b1);

      cyc(5);
      finish_run();
   end
endmodule